// File: doc/BRIEF.md
# BCD Calendar Clock with Torn-Read Flags

This block holds the current time and date as packed BCD bytes: seconds, minutes, 24-hour hours, a one-hot weekday, day of month, month and a two-digit year. A single-cycle pulse on `tick`, once per second, advances the count. Carries ripple through month lengths, February in leap years, the 99-to-00 year wrap and the weekday rotation. Software reaches the registers through a small parallel bus. A write takes effect at the next clock edge. A read is combinational from the address.

While the host reads the registers, it holds `ce` high. Five of the registers have a flag in bit 7 that records any carry arriving into that register during this window. If software finds a flag set, its snapshot may mix values from before and after the carry, and it must read again. The flags clear while `ce` is low.

A separate control byte holds an oscillator-stop flag, set by `osc_fail`, and seven bits of scratch storage. Other bits that the counters do not use also act as plain storage. The time registers have no reset: they hold unknown values until software writes them.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD and carry on 59. Hours count 00 to 23 and carry into the day on 23. The register map is: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 control.
- R2: The day rolls to 01 and carries into the month after 30 in months 04, 06, 09 and 11. It does the same after 31 in the other months, and after 28 or 29 in month 02.
- R3: A year whose two BCD digits form a number divisible by 4 (including 00) is a leap year, and February then ends on day 29.
- R4: The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R5: The weekday field (bits 6:0, bit 0 Sunday up to bit 6 Saturday) rotates left by one on each day carry, so bit 6 moves to bit 0. A written value is not forced to one-hot, and any pattern rotates the same way.
- R6: Bit 7 of registers 1 to 5 is a read flag. It sets at an edge where a carry arrives into that register while `ce` is high. All read flags are 0 after reset and after any edge with `ce` low. Writes to these bits are ignored.
- R7: Bits the counters do not use keep their written value while the count advances. These are seconds bit 7, hours bit 6, day bit 6 and month bits 6:5. Register 6 uses all eight bits for the year.
- R8: A write to a register in the same cycle as an increment of that register wins. The increment is dropped, and so is any carry it would have produced.
- R9: Register 7 bit 7 is the oscillator-stop flag. It is 1 after reset and sets at any edge with `osc_fail` high. It clears only when register 7 is written with bit 7 at 0, and writing 1 has no effect. Bits 6:0 of register 7 are storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| tick | input | 1 | One-cycle pulse per second |
| osc_fail | input | 1 | Oscillator failure indication |
| ce | input | 1 | High while the host holds a read window open |
| we | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |

## Verification
A wrong carry condition or a wrong month-length decision shows up at the next clock edge as a wrong byte in the day, month or year register. It is visible on `rdata` in the same cycle once addressed. An error in the weekday rotation or in the storage-bit masking appears on the first day carry after the fault, so the bench drives many crossings of midnight, month end and year end. A read flag that sets or clears in the wrong cycle appears in bit 7 one edge after the carry or after `ce` falls. The bench therefore reads back every register after every clock and compares it with an integer-based model.

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       osc_fail,
  input  logic       ce,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [7:0] sec, yr;
  logic [6:0] mn, hr, wd, dy, mo, gp;
  logic [4:0] rf;
  logic       osc;
  logic [7:0] wsel;
  logic [5:0] last_day;
  logic       leap, c_mn, c_hr, c_dy, c_mo, c_yr;

  function automatic logic [6:0] inc7(input logic [6:0] v);
    return (v[3:0] == 4'd9) ? {v[6:4] + 3'd1, 4'd0} : v + 7'd1;
  endfunction

  function automatic logic [6:0] step(input logic [6:0] v, input logic [6:0] keep);
    return (inc7(v & ~keep) & ~keep) | (v & keep);
  endfunction

  assign wsel = we ? (8'b1 << addr) : 8'b0;
  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mo[4:0])
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  assign c_mn = tick & ~wsel[0] & (sec[6:0] == 7'h59);
  assign c_hr = c_mn & ~wsel[1] & (mn == 7'h59);
  assign c_dy = c_hr & ~wsel[2] & (hr[5:0] == 6'h23);
  assign c_mo = c_dy & ~wsel[4] & (dy[5:0] == last_day);
  assign c_yr = c_mo & ~wsel[5] & (mo[4:0] == 5'h12);

  always_ff @(posedge clk) begin
    if (wsel[0])   sec <= wdata;
    else if (tick) sec[6:0] <= (sec[6:0] == 7'h59) ? 7'h00 : inc7(sec[6:0]);

    if (wsel[1])   mn <= wdata[6:0];
    else if (c_mn) mn <= (mn == 7'h59) ? 7'h00 : inc7(mn);

    if (wsel[2])   hr <= wdata[6:0];
    else if (c_hr) hr <= (hr[5:0] == 6'h23) ? {hr[6], 6'h00} : step(hr, 7'h40);

    if (wsel[3])   wd <= wdata[6:0];
    else if (c_dy) wd <= {wd[5:0], wd[6]};

    if (wsel[4])   dy <= wdata[6:0];
    else if (c_dy) dy <= (dy[5:0] == last_day) ? {dy[6], 6'h01} : step(dy, 7'h40);

    if (wsel[5])   mo <= wdata[6:0];
    else if (c_mo) mo <= (mo[4:0] == 5'h12) ? {mo[6:5], 5'h01} : step(mo, 7'h60);

    if (wsel[6])   yr <= wdata;
    else if (c_yr) yr <= (yr == 8'h99) ? 8'h00
                        : (yr[3:0] == 4'd9) ? {yr[7:4] + 4'd1, 4'd0} : yr + 8'd1;

    if (wsel[7])   gp <= wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf  <= 5'd0;
      osc <= 1'b1;
    end else begin
      rf <= ce ? (rf | {c_mo, c_dy, c_dy, c_hr, c_mn}) : 5'd0;
      if (osc_fail)                 osc <= 1'b1;
      else if (wsel[7] && !wdata[7]) osc <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = sec;
      3'd1:    rdata = {rf[0], mn};
      3'd2:    rdata = {rf[1], hr};
      3'd3:    rdata = {rf[2], wd};
      3'd4:    rdata = {rf[3], dy};
      3'd5:    rdata = {rf[4], mo};
      3'd6:    rdata = yr;
      default: rdata = {osc, gp};
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
`timescale 1ns/1ps
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       osc_fail,
  input logic       ce,
  input logic       we,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] sec,
  input logic [6:0] mn,
  input logic [6:0] hr,
  input logic [4:0] rf,
  input logic       osc
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(we && addr == 3'd0) && sec[6:0] == 7'h59 |=> sec[6:0] == 7'h00); // R1
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !we && sec[6:0] == 7'h59 && mn == 7'h59 && hr[5:0] == 6'h23 |=> hr[5:0] == 6'h00); // R1
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> rf == 5'd0); // R6
  AST_MIN_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ce && tick && !we && sec[6:0] == 7'h59 |=> rf[0]); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == 3'd0 |=> sec == $past(wdata)); // R8
  AST_OSC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc); // R9
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_fail && !(we && addr == 3'd7) |=> $stable(osc)); // R9
endmodule

bind bcd_calendar bcd_calendar_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .osc_fail(osc_fail), .ce(ce),
  .we(we), .addr(addr), .wdata(wdata), .sec(sec), .mn(mn), .hr(hr),
  .rf(rf), .osc(osc)
);

// File: tb/test_bcd_calendar.sv
`timescale 1ns/100ps
module test_bcd_calendar;
  logic clk = 0, rst_n = 0, tick = 0, osc_fail = 0, ce = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit chk_en = 0;

  always #10 clk = ~clk;

  bcd_calendar i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_fail(osc_fail), .ce(ce),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata));

  int s, m, h, d, mo, y;
  logic [6:0] wd = 0, gp = 0;
  logic gs7 = 0, gh6 = 0, gd6 = 0, osc = 1;
  logic [1:0] gmo = 0;
  logic [4:0] f = 0;

  function automatic logic [7:0] i2b(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(int mon, int yy);
    if (mon == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic string tag_of(int a);
    case (a)
      3: return "R5";
      4: return "R2";
      5, 6: return "R4";
      7: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    logic [7:0] t;
    case (a)
      0: begin t = i2b(s); t[7] = gs7; end
      1: begin t = i2b(m); t[7] = f[0]; end
      2: begin t = i2b(h); t[7] = f[1]; t[6] = gh6; end
      3: t = {f[2], wd};
      4: begin t = i2b(d); t[7] = f[3]; t[6] = gd6; end
      5: begin t = i2b(mo); t[7] = f[4]; t[6:5] = gmo; end
      6: t = i2b(y);
      default: t = {osc, gp};
    endcase
    return t;
  endfunction

  task automatic model_step(logic w, int a, logic [7:0] dat, logic tk);
    bit cm, ch, cd, cmo, cy;
    int last;
    last = dim(mo, y);
    cm  = tk && !(w && a == 0) && s == 59;
    ch  = cm && !(w && a == 1) && m == 59;
    cd  = ch && !(w && a == 2) && h == 23;
    cmo = cd && !(w && a == 4) && d == last;
    cy  = cmo && !(w && a == 5) && mo == 12;
    if (tk && !(w && a == 0)) s = (s + 1) % 60;
    if (cm && !(w && a == 1)) m = (m + 1) % 60;
    if (ch && !(w && a == 2)) h = (h + 1) % 24;
    if (cd && !(w && a == 3)) wd = {wd[5:0], wd[6]};
    if (cd && !(w && a == 4)) d = (d == last) ? 1 : d + 1;
    if (cmo && !(w && a == 5)) mo = (mo == 12) ? 1 : mo + 1;
    if (cy && !(w && a == 6)) y = (y + 1) % 100;
    if (w) begin
      case (a)
        0: begin s = b2i({1'b0, dat[6:0]}); gs7 = dat[7]; end
        1: m = b2i({1'b0, dat[6:0]});
        2: begin h = b2i({2'b0, dat[5:0]}); gh6 = dat[6]; end
        3: wd = dat[6:0];
        4: begin d = b2i({2'b0, dat[5:0]}); gd6 = dat[6]; end
        5: begin mo = b2i({3'b0, dat[4:0]}); gmo = dat[6:5]; end
        6: y = b2i(dat);
        default: gp = dat[6:0];
      endcase
    end
    f = ce ? (f | {cmo, cd, cd, ch, cm}) : 5'd0;
    if (osc_fail) osc = 1;
    else if (w && a == 7 && !dat[7]) osc = 0;
  endtask

  task automatic chk(string tag, int a, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, act, exp);
    end
  endtask

  task automatic cycle(logic w, int a, logic [7:0] dat, logic tk);
    @(negedge clk);
    we = w; addr = 3'(a); wdata = dat; tick = tk;
    model_step(w, a, dat, tk);
    @(posedge clk);
    #1;
    we = 0; tick = 0;
    if (chk_en)
      for (int i = 0; i < 8; i++) begin
        addr = 3'(i);
        #0.5;
        chk(tag_of(i), i, rdata, exp_rd(i));
      end
  endtask

  task automatic lit(string tag, int a, logic [7:0] exp);
    cycle(0, 0, 8'h00, 0);
    addr = 3'(a);
    #0.5;
    chk(tag, a, rdata, exp);
  endtask

  task automatic put(int a, logic [7:0] v);
    cycle(1, a, v, 0);
  endtask

  task automatic midnight(logic [7:0] yy, logic [7:0] mm, logic [7:0] dd, logic [7:0] ww);
    put(6, yy); put(5, mm); put(4, dd); put(3, ww);
    put(2, 8'h23); put(1, 8'h59); put(0, 8'h59);
    cycle(0, 0, 8'h00, 1);
  endtask

  function automatic logic [7:0] rnd_val(int a);
    logic [7:0] t;
    logic [7:0] r;
    r = 8'($urandom);
    case (a)
      0: begin t = i2b($urandom % 60); t[7] = r[7]; end
      1: begin t = i2b($urandom % 60); t[7] = r[7]; end
      2: begin t = i2b($urandom % 24); t[7:6] = r[7:6]; end
      3: t = r;
      4: begin t = i2b(1 + $urandom % 28); t[7:6] = r[7:6]; end
      5: begin t = i2b(1 + $urandom % 12); t[7:5] = r[7:5]; end
      6: t = i2b($urandom % 100);
      default: t = r;
    endcase
    return t;
  endfunction

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0;
    repeat (3) @(posedge clk);
    #2;
    addr = 3'd7; #1;
    chk("R9", 7, {rdata[7], 7'b0}, 8'h80);
    addr = 3'd1; #1;
    chk("R6", 1, {rdata[7], 7'b0}, 8'h00);
    @(negedge clk); rst_n = 1;

    put(0, 8'h00); put(1, 8'h00); put(2, 8'h00); put(3, 8'h01);
    put(4, 8'h01); put(5, 8'h01); put(6, 8'h00); put(7, 8'h00);
    chk_en = 1;

    // R8: write to seconds wins over the tick and blocks the minute carry
    put(1, 8'h10); put(0, 8'h59);
    cycle(1, 0, 8'h30, 1);
    lit("R8", 0, 8'h30);
    lit("R8", 1, 8'h10);

    // R1, R2, R3: non-leap February end
    midnight(8'h23, 8'h02, 8'h28, 8'h01);
    lit("R1", 2, 8'h00);
    lit("R3", 4, 8'h01);
    lit("R2", 5, 8'h03);

    // R3: leap years 24 and 00
    midnight(8'h24, 8'h02, 8'h28, 8'h01);
    lit("R3", 4, 8'h29);
    put(2, 8'h23); put(1, 8'h59); put(0, 8'h59);
    cycle(0, 0, 8'h00, 1);
    lit("R3", 5, 8'h03);
    midnight(8'h00, 8'h02, 8'h28, 8'h01);
    lit("R3", 4, 8'h29);

    // R2: 30- and 31-day months
    midnight(8'h25, 8'h04, 8'h30, 8'h01);
    lit("R2", 5, 8'h05);
    midnight(8'h25, 8'h01, 8'h30, 8'h01);
    lit("R2", 4, 8'h31);

    // R4: year end
    midnight(8'h99, 8'h12, 8'h31, 8'h01);
    lit("R4", 6, 8'h00);
    lit("R4", 5, 8'h01);

    // R5: Saturday to Sunday, and a non-one-hot pattern
    midnight(8'h25, 8'h03, 8'h10, 8'h40);
    lit("R5", 3, 8'h01);
    midnight(8'h25, 8'h03, 8'h10, 8'h05);
    lit("R5", 3, 8'h0A);

    // R6: read flag during an open read window
    put(1, 8'h10); put(0, 8'h59);
    ce = 1;
    cycle(0, 0, 8'h00, 1);
    lit("R6", 1, 8'h91);
    ce = 0;
    lit("R6", 1, 8'h11);
    put(1, 8'h92);
    lit("R6", 1, 8'h12);

    // R7: storage bits survive the count
    put(0, 8'hD9);
    cycle(0, 0, 8'h00, 1);
    lit("R7", 0, 8'h80);
    put(6, 8'h25); put(5, 8'h63); put(4, 8'h45); put(3, 8'h01);
    put(2, 8'h63); put(1, 8'h59); put(0, 8'h59);
    cycle(0, 0, 8'h00, 1);
    lit("R7", 2, 8'h40);
    lit("R7", 4, 8'h46);
    lit("R7", 5, 8'h63);

    // R9: oscillator-stop flag
    put(7, 8'h00);
    lit("R9", 7, 8'h00);
    put(7, 8'h80);
    lit("R9", 7, 8'h00);
    osc_fail = 1;
    cycle(0, 0, 8'h00, 0);
    osc_fail = 0;
    lit("R9", 7, 8'h80);
    put(7, 8'h55);
    lit("R9", 7, 8'h55);

    // constrained random mix, compared with the model after every edge
    for (int i = 0; i < 600; i++) begin
      logic w, tk;
      int a;
      logic [7:0] v;
      if ($urandom % 6 == 0) ce = ~ce;
      if ($urandom % 40 == 0) osc_fail = 1;
      w = ($urandom % 3 == 0);
      a = $urandom % 8;
      v = rnd_val(a);
      if ($urandom % 4 == 0) begin
        w = 1; a = 0; v = 8'h59;
      end else if ($urandom % 10 == 0) begin
        w = 1; a = 1; v = 8'h59;
      end else if ($urandom % 20 == 0) begin
        w = 1; a = 2; v = 8'h23;
      end
      tk = ($urandom % 2 == 0);
      cycle(w, a, v, tk);
      osc_fail = 0;
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule